// File: doc/BRIEF.md
# Address Translation Cache with Selective Flush

This block is a small, fully associative cache of page translations. It sits beside an address path and turns a virtual address into a physical one without touching the page tables. Each slot holds a virtual page number, a physical frame number, a valid flag and a global flag. A lookup is answered in the same cycle. On a hit, the physical address is the cached frame joined to the untranslated page offset. On a miss, the block raises a refill request toward an external table walker.

The walker answers through a response port. If the walker reports the translation present, the block installs it on the next clock edge. If the walker reports it not present, the block raises a page fault in the same cycle and installs nothing.

Changes to the page tables never reach the cache by themselves. Software must maintain it with two commands. A page-table base write drops every slot that is not marked global. A single-page invalidate drops the slot that matches one virtual page, whether or not that slot is global, and leaves every other slot as it was.

Top module: `xc_tlb`

## Requirements
- R1: While reset is held, and in every cycle after reset until a refill is installed, every slot is invalid and every lookup misses. This includes slots that were installed as global.
- R2: When `lk_valid` is high and the page number `lk_vaddr[31:12]` matches a valid slot, `lk_hit` is 1 in the same cycle, `lk_paddr` equals {stored frame, `lk_vaddr[11:0]`} and `fill_req` is 0.
- R3: When `lk_valid` is high and no valid slot matches, `lk_hit` is 0, `lk_paddr` is 0, and `fill_req` is 1 in the same cycle with `fill_vpn` equal to `lk_vaddr[31:12]`. When `lk_valid` is low, `lk_hit`, `lk_paddr` and `fill_req` are all 0.
- R4: A walker response with `wk_valid`=1 and `wk_present`=1 installs (`wk_vpn`, `wk_pfn`, `wk_global`) at the next clock edge, so later lookups of that page hit. If that page is already cached, its slot is overwritten in place, and no page ever occupies two slots.
- R5: A walker response with `wk_valid`=1 and `wk_present`=0 drives `page_fault` to 1 in the same cycle and changes no slot. In every other cycle `page_fault` is 0.
- R6: A cycle with `base_wr`=1 invalidates, at the next edge, every slot whose global flag is 0. Slots whose global flag is 1 stay valid with their translations unchanged.
- R7: A cycle with `inv_valid`=1 invalidates, at the next edge, only the slot whose page number equals `inv_vaddr[31:12]`, even if that slot is global. All other slots are unchanged.
- R8: A refill of a page that is not cached goes to the lowest-numbered invalid slot. When every slot is valid, it goes to the slot named by a round-robin pointer. That pointer starts at slot 0 after reset and advances by one, wrapping from 7 to 0, only on such a full-cache eviction.
- R9: When `base_wr` or `inv_valid` is high in the same cycle as a present walker response, that response is dropped and nothing is installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Lookup found a valid translation |
| lk_paddr | output | 32 | Translated physical address (0 when not a hit) |
| fill_req | output | 1 | Miss: refill requested from the walker |
| fill_vpn | output | 20 | Page number to be walked |
| wk_valid | input | 1 | Walker response strobe |
| wk_present | input | 1 | Walker found a present entry |
| wk_global | input | 1 | Entry is global |
| wk_vpn | input | 20 | Page number of the response |
| wk_pfn | input | 20 | Frame number of the response |
| page_fault | output | 1 | Walker reported the entry not present |
| base_wr | input | 1 | Page-table base write: flush non-global slots |
| inv_valid | input | 1 | Single-page invalidate command |
| inv_vaddr | input | 32 | Address whose page is invalidated |

## Verification
The situation hardest to reach from the ports is a full cache in which the round-robin pointer has already moved, combined with global slots that survive a base write and are later removed one by one. The stimulus fills all eight slots with distinct pages, then adds several more to push the pointer past several slots. It overwrites a page that is already cached, flushes, invalidates single pages, and refills into the holes the flush left. A behavioural model that keeps slots in plain arrays predicts every output in every cycle. Walker responses that arrive together with a maintenance command check that those responses are dropped.

// File: rtl/xc_pkg.sv
package xc_pkg;
    // Where a refill lands
    typedef enum logic [1:0] {
        SLOT_SAME  = 2'd0,  // page already cached: overwrite in place
        SLOT_FREE  = 2'd1,  // lowest invalid slot
        SLOT_ROBIN = 2'd2   // cache full: round-robin victim
    } slot_src_e;
endpackage

// File: rtl/xc_match.sv
module xc_match #(
    parameter int N     = 8,
    parameter int VPN_W = 20,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]            valid,
    input  logic [N-1:0][VPN_W-1:0] tags,
    input  logic [VPN_W-1:0]        key,
    output logic [N-1:0]            hit_vec,
    output logic                    any,
    output logic [IDX_W-1:0]        idx
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (tags[g] == key);
    end

    assign any = |hit_vec;

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/xc_slot_pick.sv
module xc_slot_pick
    import xc_pkg::*;
#(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     valid,
    input  logic             same_any,
    input  logic [IDX_W-1:0] same_idx,
    input  logic [IDX_W-1:0] rr_ptr,
    output logic [IDX_W-1:0] slot,
    output slot_src_e        src
);
    logic [IDX_W-1:0] free_idx;
    logic             free_any;

    always_comb begin
        free_idx = '0;
        free_any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_idx = IDX_W'(i);
                free_any = 1'b1;
            end
        end
    end

    always_comb begin
        if (same_any) begin
            slot = same_idx;
            src  = SLOT_SAME;
        end else if (free_any) begin
            slot = free_idx;
            src  = SLOT_FREE;
        end else begin
            slot = rr_ptr;
            src  = SLOT_ROBIN;
        end
    end
endmodule

// File: rtl/xc_tlb.sv
module xc_tlb
    import xc_pkg::*;
#(
    parameter int N      = 8,
    parameter int VA_W   = 32,
    parameter int OFF_W  = 12,
    parameter int PFN_W  = 20,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int PA_W  = PFN_W + OFF_W,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             lk_hit,
    output logic [PA_W-1:0]  lk_paddr,
    output logic             fill_req,
    output logic [VPN_W-1:0] fill_vpn,
    input  logic             wk_valid,
    input  logic             wk_present,
    input  logic             wk_global,
    input  logic [VPN_W-1:0] wk_vpn,
    input  logic [PFN_W-1:0] wk_pfn,
    output logic             page_fault,
    input  logic             base_wr,
    input  logic             inv_valid,
    input  logic [VA_W-1:0]  inv_vaddr
);
    typedef struct packed {
        logic [N-1:0]            vld;
        logic [N-1:0]            glb;
        logic [N-1:0][VPN_W-1:0] vpn;
        logic [N-1:0][PFN_W-1:0] pfn;
        logic [IDX_W-1:0]        rr;
    } state_t;

    state_t st_d, st_q;

    // Lookup port
    logic [N-1:0]     lk_hv;
    logic             lk_any;
    logic [IDX_W-1:0] lk_idx;

    xc_match #(.N(N), .VPN_W(VPN_W)) u_lk_match (
        .valid   (st_q.vld),
        .tags    (st_q.vpn),
        .key     (lk_vaddr[VA_W-1:OFF_W]),
        .hit_vec (lk_hv),
        .any     (lk_any),
        .idx     (lk_idx)
    );

    // Single-page invalidate
    logic [N-1:0]     inv_hv;
    logic             inv_any;
    logic [IDX_W-1:0] inv_idx;

    xc_match #(.N(N), .VPN_W(VPN_W)) u_inv_match (
        .valid   (st_q.vld),
        .tags    (st_q.vpn),
        .key     (inv_vaddr[VA_W-1:OFF_W]),
        .hit_vec (inv_hv),
        .any     (inv_any),
        .idx     (inv_idx)
    );

    // Refill: is the page already cached?
    logic [N-1:0]     wk_hv;
    logic             wk_any;
    logic [IDX_W-1:0] wk_idx;

    xc_match #(.N(N), .VPN_W(VPN_W)) u_wk_match (
        .valid   (st_q.vld),
        .tags    (st_q.vpn),
        .key     (wk_vpn),
        .hit_vec (wk_hv),
        .any     (wk_any),
        .idx     (wk_idx)
    );

    logic [IDX_W-1:0] fill_slot;
    slot_src_e        fill_src;

    xc_slot_pick #(.N(N)) u_pick (
        .valid    (st_q.vld),
        .same_any (wk_any),
        .same_idx (wk_idx),
        .rr_ptr   (st_q.rr),
        .slot     (fill_slot),
        .src      (fill_src)
    );

    logic maint;
    logic install;
    assign maint   = base_wr || inv_valid;
    assign install = wk_valid && wk_present && !maint;

    always_comb begin
        st_d = st_q;
        if (base_wr) begin
            st_d.vld = st_q.vld & st_q.glb;
        end
        if (inv_valid && inv_any) begin
            st_d.vld[inv_idx] = 1'b0;
        end
        if (install) begin
            st_d.vld[fill_slot] = 1'b1;
            st_d.glb[fill_slot] = wk_global;
            st_d.vpn[fill_slot] = wk_vpn;
            st_d.pfn[fill_slot] = wk_pfn;
            if (fill_src == SLOT_ROBIN) begin
                st_d.rr = (st_q.rr == IDX_W'(N - 1)) ? '0 : st_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lk_hit     = lk_valid && lk_any;
    assign lk_paddr   = lk_hit ? {st_q.pfn[lk_idx], lk_vaddr[OFF_W-1:0]} : '0;
    assign fill_req   = lk_valid && !lk_any;
    assign fill_vpn   = lk_vaddr[VA_W-1:OFF_W];
    assign page_fault = wk_valid && !wk_present;

    // Observation points for the bound checker
    logic [N-1:0] vld_obs, glb_obs;
    assign vld_obs = st_q.vld;
    assign glb_obs = st_q.glb;
endmodule

module xc_tlb_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         base_wr,
    input logic         inv_valid,
    input logic         wk_valid,
    input logic         wk_present,
    input logic [N-1:0] vld,
    input logic [N-1:0] glb,
    input logic [N-1:0] lk_hv,
    input logic [N-1:0] inv_hv,
    input logic [N-1:0] wk_hv
);
    // R1: first cycle after reset release sees an empty cache
    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (vld == '0));

    // R4: no page in two slots
    assert_no_dup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hv) && $onehot0(inv_hv) && $onehot0(wk_hv));

    // R5: fault response leaves every slot alone
    assert_fault_no_install_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wk_valid && !wk_present && !base_wr && !inv_valid) |=> (vld == $past(vld)));

    // R6: after base write, no valid non-global slot remains
    assert_flush_nonglobal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr |=> ((vld & ~glb) == '0));

    // R6: global slots survive base write
    assert_global_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (base_wr && !inv_valid) |=> (vld == $past(vld & glb)));

    // R7: invalidate removes at most one slot and adds none
    assert_inv_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !base_wr) |=>
            (((vld & ~$past(vld)) == '0) && ($countones($past(vld)) <= $countones(vld) + 1)));

    // R9: no slot becomes valid while a maintenance command is applied
    assert_maint_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (base_wr || inv_valid) |=> ((vld & ~$past(vld)) == '0));
endmodule

bind xc_tlb xc_tlb_chk #(.N(N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_wr    (base_wr),
    .inv_valid  (inv_valid),
    .wk_valid   (wk_valid),
    .wk_present (wk_present),
    .vld        (vld_obs),
    .glb        (glb_obs),
    .lk_hv      (lk_hv),
    .inv_hv     (inv_hv),
    .wk_hv      (wk_hv)
);

// File: tb/sim_xc_tlb.sv
`timescale 1ns/1ps
module sim_xc_tlb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid;
    logic [31:0] lk_vaddr;
    logic        lk_hit;
    logic [31:0] lk_paddr;
    logic        fill_req;
    logic [19:0] fill_vpn;
    logic        wk_valid, wk_present, wk_global;
    logic [19:0] wk_vpn, wk_pfn;
    logic        page_fault;
    logic        base_wr, inv_valid;
    logic [31:0] inv_vaddr;

    always #10 clk = ~clk; // 50 MHz

    xc_tlb u0 (.*);

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // Behavioural reference: plain arrays of slots
    bit        m_v   [8];
    bit        m_g   [8];
    bit [19:0] m_vpn [8];
    bit [19:0] m_pfn [8];
    int        m_rr;

    function automatic int find(input bit [19:0] vpn);
        for (int i = 0; i < 8; i++) if (m_v[i] && m_vpn[i] == vpn) return i;
        return -1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin m_v[i] = 0; m_g[i] = 0; end
        m_rr = 0;
    endtask

    task automatic model_edge();
        int k;
        if (base_wr) for (int i = 0; i < 8; i++) if (!m_g[i]) m_v[i] = 0;
        if (inv_valid) begin
            k = find(inv_vaddr[31:12]);
            if (k >= 0) m_v[k] = 0;
        end
        if (!base_wr && !inv_valid && wk_valid && wk_present) begin
            k = find(wk_vpn);
            if (k < 0) for (int i = 7; i >= 0; i--) if (!m_v[i]) k = i;
            if (k < 0) begin k = m_rr; m_rr = (m_rr + 1) % 8; end
            m_v[k] = 1; m_g[k] = wk_global; m_vpn[k] = wk_vpn; m_pfn[k] = wk_pfn;
        end
    endtask

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        lk_valid = 0; lk_vaddr = '0;
        wk_valid = 0; wk_present = 0; wk_global = 0; wk_vpn = '0; wk_pfn = '0;
        base_wr = 0; inv_valid = 0; inv_vaddr = '0;
    endtask

    // Inputs are set just after a falling edge; compare mid-phase, then
    // advance the model with the rising edge.
    task automatic step(input string tag);
        int hi;
        bit exp_hit;
        logic [31:0] exp_pa;
        #5;
        hi      = lk_valid ? find(lk_vaddr[31:12]) : -1;
        exp_hit = (hi >= 0);
        exp_pa  = exp_hit ? {m_pfn[hi], lk_vaddr[11:0]} : 32'h0;
        check(tag, "lk_hit",     32'(lk_hit),     32'(exp_hit));
        check(tag, "lk_paddr",   lk_paddr,        exp_pa);
        check(tag, "fill_req",   32'(fill_req),   32'(lk_valid && !exp_hit));
        check(tag, "page_fault", 32'(page_fault), 32'(wk_valid && !wk_present));
        if (lk_valid && !exp_hit) check(tag, "fill_vpn", 32'(fill_vpn), 32'(lk_vaddr[31:12]));
        @(posedge clk);
        model_edge();
        @(negedge clk);
        idle();
    endtask

    task automatic look(input bit [19:0] vpn, input string tag);
        lk_valid = 1; lk_vaddr = {vpn, 12'h5A4};
        step(tag);
    endtask

    task automatic fill(input bit [19:0] vpn, input bit [19:0] pfn,
                        input bit g, input string tag);
        wk_valid = 1; wk_present = 1; wk_global = g; wk_vpn = vpn; wk_pfn = pfn;
        step(tag);
    endtask

    task automatic scan(input bit [19:0] base, input int n, input string tag);
        for (int i = 0; i < n; i++) look(base + 20'(i), tag);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: empty after reset
        look(20'h12345, "R1");
        look(20'h00000, "R1");
        // R3: miss with idle lookup too
        step("R3");
        look(20'hFFFFF, "R3");

        // R4 / R2: install then hit
        fill(20'h12345, 20'hABCDE, 0, "R4");
        look(20'h12345, "R2");
        lk_valid = 1; lk_vaddr = 32'h12345FFF; step("R2");

        // R5: fault, nothing installed
        wk_valid = 1; wk_present = 0; wk_vpn = 20'h22222; wk_pfn = 20'h33333; step("R5");
        look(20'h22222, "R5");

        // R4: overwrite in place, no duplicate
        fill(20'h12345, 20'h54321, 0, "R4");
        look(20'h12345, "R4");

        // R6: globals survive base write
        fill(20'h00001, 20'h10001, 1, "R6");
        fill(20'h00002, 20'h10002, 0, "R6");
        base_wr = 1; step("R6");
        look(20'h00001, "R6");
        look(20'h00002, "R6");
        look(20'h12345, "R6");

        // R9: refill dropped under base write and under invalidate
        base_wr = 1; wk_valid = 1; wk_present = 1; wk_vpn = 20'h00044; wk_pfn = 20'h1; step("R9");
        look(20'h00044, "R9");
        inv_valid = 1; inv_vaddr = 32'h7777_7000;
        wk_valid = 1; wk_present = 1; wk_vpn = 20'h00045; wk_pfn = 20'h2; step("R9");
        look(20'h00045, "R9");

        // R7: invalidate a global slot, then a single slot among many
        inv_valid = 1; inv_vaddr = 32'h0000_1ABC; step("R7");
        look(20'h00001, "R7");
        for (int i = 0; i < 5; i++) fill(20'h00100 + 20'(i), 20'h20000 + 20'(i), i[0], "R7");
        inv_valid = 1; inv_vaddr = 32'h0010_2000; step("R7");
        scan(20'h00100, 5, "R7");

        // R8: fill past capacity, round-robin victims
        for (int i = 0; i < 12; i++) fill(20'h00200 + 20'(i), 20'h30000 + 20'(i), 0, "R8");
        scan(20'h00100, 5, "R8");
        scan(20'h00200, 12, "R8");
        base_wr = 1; step("R8");
        fill(20'h00300, 20'h40000, 0, "R8");
        fill(20'h00301, 20'h40001, 0, "R8");
        scan(20'h00100, 5, "R8");
        scan(20'h00300, 2, "R8");
        for (int i = 0; i < 9; i++) fill(20'h00400 + 20'(i), 20'h50000 + 20'(i), 1, "R8");
        scan(20'h00400, 9, "R8");
        base_wr = 1; step("R6");
        scan(20'h00400, 9, "R6");

        // R1: reset clears global slots too
        @(posedge clk);
        rst_n = 0;
        model_reset();
        @(negedge clk);
        rst_n = 1;
        scan(20'h00400, 9, "R1");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule